// File: doc/BRIEF.md
# APB Shadow-Register Read Checker

This block sits beside one APB slave and only watches it. It keeps its own shadow copy of the slave's register space and a short in-order list of transactions the stimulus expects to see. Each completed bus transfer is paired with the oldest expected entry. An expected write loads its data into the shadow copy at its address. An expected read is scored by comparing the data the slave returned with the shadow word at that address, as the word stands at the moment of the check.

Mismatches in direction, address or read data set separate sticky flags. They also pulse a one-cycle error strobe, step a mismatch counter and capture the observed address with the expected and actual data. Two further sticky flags report misuse of the expected list: a push into a full list, and a completed transfer that arrives while no expectation is waiting. Stimulus enters through a single-cycle push port.

Top module: `apb_shadow_checker`

## Requirements
- R1: A transfer is complete only on a rising `pclk` edge where `psel`, `penable` and `pready` are all high. Setup cycles and wait cycles (`pready` low) neither pop an expectation nor raise any flag.
- R2: The expected list holds 8 entries. Completed transfers consume them oldest first, one per transfer, so transfers seen in a different order from the pushes are reported as address mismatches.
- R3: A push (`exp_push` high) while the list holds 8 entries, with no transfer completing in that cycle, is dropped and sets the sticky `sticky_ovf`.
- R4: A completed transfer while the list is empty sets the sticky `sticky_unexp`. It does not change `mism_cnt` or pulse `mism_pulse`.
- R5: A direction mismatch sets the sticky `sticky_dir`. Direction is encoded as 1 = write and 0 = read, both on `exp_write` and on `pwrite`.
- R6: If the full `paddr` differs from the expected address, the sticky `sticky_addr` is set.
- R7: When an expected write is consumed, its data is written into shadow word `exp_addr[5:2]`. A later expected read of that address compares against this value.
- R8: When an expected read meets an observed read, `prdata` is compared with shadow word `exp_addr[5:2]`. A difference sets the sticky `sticky_data`. The data pushed with a read entry is ignored.
- R9: A check with any mismatch raises `mism_pulse` for exactly the next cycle and adds one to `mism_cnt`. It also loads `cap_addr` with `paddr`, `cap_exp` with the expected value (shadow word for reads, pushed data for writes) and `cap_act` with the observed value (`prdata` for reads, `pwdata` for writes).
- R10: Reset is active-low and synchronous to `pclk`. It empties the list, zeroes the counter, flags and capture registers, and clears all 16 shadow words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select observed on the bus |
| penable | input | 1 | Access-phase strobe observed on the bus |
| pready | input | 1 | Slave ready observed on the bus |
| pwrite | input | 1 | Observed direction, 1 = write |
| paddr | input | 16 | Observed byte address |
| pwdata | input | 32 | Observed write data |
| prdata | input | 32 | Observed read data |
| exp_push | input | 1 | Push one expected transaction this cycle |
| exp_write | input | 1 | Expected direction, 1 = write |
| exp_addr | input | 16 | Expected byte address |
| exp_data | input | 32 | Expected write data (ignored for reads) |
| mism_pulse | output | 1 | One-cycle strobe after a mismatching check |
| sticky_dir | output | 1 | Direction mismatch seen |
| sticky_addr | output | 1 | Address mismatch seen |
| sticky_data | output | 1 | Read data mismatch seen |
| sticky_unexp | output | 1 | Transfer completed with no expectation waiting |
| sticky_ovf | output | 1 | Push dropped because the list was full |
| mism_cnt | output | 16 | Number of mismatching checks |
| cap_addr | output | 16 | Observed address of the latest mismatch |
| cap_exp | output | 32 | Expected value of the latest mismatch |
| cap_act | output | 32 | Observed value of the latest mismatch |

## Verification
A shadow word that holds the wrong value stays hidden until an expected read of that word is consumed. It then shows on the edge that completes that read, as `mism_pulse`, a counter step and a `cap_exp` that differs from the bench's arithmetic model. Sweeping every word with a write and then a read pass puts a bound on how long such an error can stay hidden. A corrupted list pointer or occupancy count shows up as address mismatches on the next consumed entry, or as an early or missing `sticky_ovf` or `sticky_unexp`. Filling the list to its depth and one beyond exposes these faults within nine transfers.

// File: rtl/apb_chk_pkg.sv
package apb_chk_pkg;
   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } dir_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/apb_chk_fifo.sv
module apb_chk_fifo #(
   parameter int W     = 49,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (!apb_chk_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("apb_chk_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;

   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/apb_chk_shadow.sv
module apb_chk_shadow #(
   parameter int DW    = 32,
   parameter int WORDS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [$clog2(WORDS)-1:0] raddr,
   output logic [DW-1:0]            rdata
);
   if (!apb_chk_pkg::is_pow2(WORDS) || WORDS < 2) begin : g_bad_words
      $error("apb_chk_shadow: WORDS must be a power of two of at least 2");
   end

   logic [DW-1:0] words [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [DW-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                     word_q <= '0;
         else if (we && waddr == $clog2(WORDS)'(g))      word_q <= wdata;
      end
      assign words[g] = word_q;
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/apb_chk_compare.sv
module apb_chk_compare #(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic          exp_wr,
   input  logic [AW-1:0] exp_addr,
   input  logic [DW-1:0] exp_data,
   input  logic [DW-1:0] shadow_data,
   input  logic          obs_wr,
   input  logic [AW-1:0] obs_addr,
   input  logic [DW-1:0] obs_wdata,
   input  logic [DW-1:0] obs_rdata,
   output logic          dir_mis,
   output logic          addr_mis,
   output logic          data_mis,
   output logic [DW-1:0] exp_val,
   output logic [DW-1:0] act_val
);
   import apb_chk_pkg::*;

   always_comb begin
      dir_mis  = (exp_wr != obs_wr);
      addr_mis = (exp_addr != obs_addr);
      data_mis = (dir_e'(exp_wr) == DIR_READ) && (dir_e'(obs_wr) == DIR_READ)
                 && (obs_rdata != shadow_data);
      exp_val  = exp_wr ? exp_data  : shadow_data;
      act_val  = obs_wr ? obs_wdata : obs_rdata;
   end
endmodule

// File: rtl/apb_shadow_checker.sv
module apb_shadow_checker #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int REG_WORDS = 16,
   parameter int Q_DEPTH   = 8,
   parameter int CNT_W     = 16
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pready,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  logic [DATA_W-1:0] prdata,
   input  logic              exp_push,
   input  logic              exp_write,
   input  logic [ADDR_W-1:0] exp_addr,
   input  logic [DATA_W-1:0] exp_data,
   output logic              mism_pulse,
   output logic              sticky_dir,
   output logic              sticky_addr,
   output logic              sticky_data,
   output logic              sticky_unexp,
   output logic              sticky_ovf,
   output logic [CNT_W-1:0]  mism_cnt,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_exp,
   output logic [DATA_W-1:0] cap_act
);
   localparam int IDX_W   = $clog2(REG_WORDS);
   localparam int IDX_LSB = $clog2(DATA_W / 8);
   localparam int ENT_W   = 1 + ADDR_W + DATA_W;

   if (ADDR_W < IDX_LSB + IDX_W) begin : g_bad_addr
      $error("apb_shadow_checker: ADDR_W too narrow for REG_WORDS");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("apb_shadow_checker: DATA_W must be a whole number of bytes");
   end

   logic              xfer, pop, push_ok;
   logic              q_empty, q_full;
   logic [ENT_W-1:0]  head;
   logic              h_wr;
   logic [ADDR_W-1:0] h_addr;
   logic [DATA_W-1:0] h_data, sh_rdata, exp_val, act_val;
   logic              dir_mis, addr_mis, data_mis, any_mis;

   assign xfer    = psel & penable & pready;
   assign pop     = xfer & ~q_empty;
   assign push_ok = exp_push & (~q_full | pop);
   assign {h_wr, h_addr, h_data} = head;

   apb_chk_fifo #(.W(ENT_W), .DEPTH(Q_DEPTH)) u_queue (
      .clk   (pclk),
      .rst_n (presetn),
      .push  (push_ok),
      .pop   (pop),
      .din   ({exp_write, exp_addr, exp_data}),
      .dout  (head),
      .empty (q_empty),
      .full  (q_full)
   );

   apb_chk_shadow #(.DW(DATA_W), .WORDS(REG_WORDS)) u_shadow (
      .clk   (pclk),
      .rst_n (presetn),
      .we    (pop & h_wr),
      .waddr (h_addr[IDX_LSB +: IDX_W]),
      .wdata (h_data),
      .raddr (h_addr[IDX_LSB +: IDX_W]),
      .rdata (sh_rdata)
   );

   apb_chk_compare #(.AW(ADDR_W), .DW(DATA_W)) u_cmp (
      .exp_wr      (h_wr),
      .exp_addr    (h_addr),
      .exp_data    (h_data),
      .shadow_data (sh_rdata),
      .obs_wr      (pwrite),
      .obs_addr    (paddr),
      .obs_wdata   (pwdata),
      .obs_rdata   (prdata),
      .dir_mis     (dir_mis),
      .addr_mis    (addr_mis),
      .data_mis    (data_mis),
      .exp_val     (exp_val),
      .act_val     (act_val)
   );

   assign any_mis = pop & (dir_mis | addr_mis | data_mis);

   always_ff @(posedge pclk) begin
      if (!presetn) begin
         mism_pulse   <= 1'b0;
         sticky_dir   <= 1'b0;
         sticky_addr  <= 1'b0;
         sticky_data  <= 1'b0;
         sticky_unexp <= 1'b0;
         sticky_ovf   <= 1'b0;
         mism_cnt     <= '0;
         cap_addr     <= '0;
         cap_exp      <= '0;
         cap_act      <= '0;
      end else begin
         mism_pulse <= any_mis;
         if (pop & dir_mis)                  sticky_dir   <= 1'b1;
         if (pop & addr_mis)                 sticky_addr  <= 1'b1;
         if (pop & data_mis)                 sticky_data  <= 1'b1;
         if (xfer & q_empty)                 sticky_unexp <= 1'b1;
         if (exp_push & q_full & ~pop)       sticky_ovf   <= 1'b1;
         if (any_mis) begin
            mism_cnt <= mism_cnt + 1'b1;
            cap_addr <= paddr;
            cap_exp  <= exp_val;
            cap_act  <= act_val;
         end
      end
   end
endmodule

// File: rtl/apb_shadow_checker_sva.sv
module apb_shadow_checker_sva #(
   parameter int CNT_W = 16
) (
   input logic             pclk,
   input logic             presetn,
   input logic             psel,
   input logic             penable,
   input logic             pready,
   input logic             exp_push,
   input logic             q_full,
   input logic             q_empty,
   input logic             pop,
   input logic             mism_pulse,
   input logic             sticky_dir,
   input logic             sticky_addr,
   input logic             sticky_data,
   input logic             sticky_unexp,
   input logic             sticky_ovf,
   input logic [CNT_W-1:0] mism_cnt
);
   assert_idle_no_pulse_R1: assert property (@(posedge pclk) disable iff (!presetn)
      !(psel && penable && pready) |=> !mism_pulse);

   assert_pulse_after_pop_R9: assert property (@(posedge pclk) disable iff (!presetn)
      mism_pulse |-> $past(pop));

   assert_cnt_step_R9: assert property (@(posedge pclk) disable iff (!presetn)
      mism_pulse |-> mism_cnt == $past(mism_cnt) + 1'b1);

   assert_cnt_hold_R9: assert property (@(posedge pclk) disable iff (!presetn)
      !mism_pulse |-> $stable(mism_cnt));

   assert_no_overflow_R3: assert property (@(posedge pclk) disable iff (!presetn)
      (exp_push && q_full && !pop) |=> sticky_ovf);

   assert_unexp_flag_R4: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && penable && pready && q_empty) |=> sticky_unexp && !mism_pulse);

   assert_dir_sticky_R5: assert property (@(posedge pclk) disable iff (!presetn)
      sticky_dir |=> sticky_dir);

   assert_addr_sticky_R6: assert property (@(posedge pclk) disable iff (!presetn)
      sticky_addr |=> sticky_addr);

   assert_data_sticky_R8: assert property (@(posedge pclk) disable iff (!presetn)
      sticky_data |=> sticky_data);

   assert_full_not_empty_R2: assert property (@(posedge pclk) disable iff (!presetn)
      !(q_full && q_empty));
endmodule

bind apb_shadow_checker apb_shadow_checker_sva #(.CNT_W(CNT_W)) u_sva (
   .pclk         (pclk),
   .presetn      (presetn),
   .psel         (psel),
   .penable      (penable),
   .pready       (pready),
   .exp_push     (exp_push),
   .q_full       (q_full),
   .q_empty      (q_empty),
   .pop          (pop),
   .mism_pulse   (mism_pulse),
   .sticky_dir   (sticky_dir),
   .sticky_addr  (sticky_addr),
   .sticky_data  (sticky_data),
   .sticky_unexp (sticky_unexp),
   .sticky_ovf   (sticky_ovf),
   .mism_cnt     (mism_cnt)
);

// File: tb/apb_shadow_checker_tb.sv
`timescale 1ns/1ps
module apb_shadow_checker_tb;
   logic        pclk = 1'b0;
   logic        presetn;
   logic        psel, penable, pready, pwrite;
   logic [15:0] paddr;
   logic [31:0] pwdata, prdata;
   logic        exp_push, exp_write;
   logic [15:0] exp_addr;
   logic [31:0] exp_data;
   logic        mism_pulse, sticky_dir, sticky_addr, sticky_data, sticky_unexp, sticky_ovf;
   logic [15:0] mism_cnt, cap_addr;
   logic [31:0] cap_exp, cap_act;

   int checks = 0;
   int errors = 0;

   always #5 pclk = ~pclk;

   apb_shadow_checker u_dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pready(pready),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .exp_push(exp_push), .exp_write(exp_write), .exp_addr(exp_addr), .exp_data(exp_data),
      .mism_pulse(mism_pulse), .sticky_dir(sticky_dir), .sticky_addr(sticky_addr),
      .sticky_data(sticky_data), .sticky_unexp(sticky_unexp), .sticky_ovf(sticky_ovf),
      .mism_cnt(mism_cnt), .cap_addr(cap_addr), .cap_exp(cap_exp), .cap_act(cap_act)
   );

   function automatic logic [31:0] pat(input int i);
      return 32'hDEAD0000 | 32'(i * 257 + 1);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge pclk);
      presetn = 1'b0;
      repeat (2) @(negedge pclk);
      presetn = 1'b1;
   endtask

   task automatic push_exp(input logic w, input logic [15:0] a, input logic [31:0] d);
      @(negedge pclk);
      exp_push = 1'b1; exp_write = w; exp_addr = a; exp_data = d;
      @(negedge pclk);
      exp_push = 1'b0;
   endtask

   task automatic bus(input logic w, input logic [15:0] a, input logic [31:0] wd,
                      input logic [31:0] rd, input int waits);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = wd; prdata = rd; pready = 1'b0;
      @(negedge pclk);
      penable = 1'b1; pready = (waits == 0);
      for (int k = 0; k < waits; k++) begin
         @(negedge pclk);
         if (k == waits - 1) pready = 1'b1;
      end
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pready = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge pclk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      presetn = 1'b0; psel = 0; penable = 0; pready = 0; pwrite = 0;
      paddr = '0; pwdata = '0; prdata = '0;
      exp_push = 0; exp_write = 0; exp_addr = '0; exp_data = '0;
      do_reset();

      // R10: reset state at the ports
      check("R10 cnt", 32'(mism_cnt), 0);
      check("R10 flags", 32'({mism_pulse, sticky_dir, sticky_addr, sticky_data, sticky_unexp, sticky_ovf}), 0);
      check("R10 cap", cap_exp | cap_act | 32'(cap_addr), 0);

      // R1: setup phase with pready high and wait cycles do not complete
      @(negedge pclk);
      psel = 1; penable = 0; pready = 1; pwrite = 1; paddr = 16'h0004;
      @(negedge pclk);
      check("R1 setup", 32'(sticky_unexp), 0);
      penable = 1; pready = 0;
      repeat (2) @(negedge pclk);
      check("R1 wait", 32'(sticky_unexp), 0);
      pready = 1;
      @(negedge pclk);
      psel = 0; penable = 0; pready = 0;
      check("R1 complete", 32'(sticky_unexp), 1);
      check("R4 no count", 32'(mism_cnt), 0);
      do_reset();

      // R7: write every shadow word through expected writes
      for (int i = 0; i < 16; i++) begin
         push_exp(1'b1, 16'(i * 4), pat(i));
         bus(1'b1, 16'(i * 4), pat(i), 32'h0, i % 3);
      end
      check("R7 writes clean", 32'(mism_cnt), 0);

      // R8: read every word back with matching data
      for (int i = 0; i < 16; i++) begin
         push_exp(1'b0, 16'(i * 4), 32'hFFFF_FFFF);
         bus(1'b0, 16'(i * 4), 32'h0, pat(i), (i + 1) % 3);
         check("R8 read match", 32'(mism_pulse), 0);
      end
      check("R8 sweep cnt", 32'(mism_cnt), 0);

      // R8/R9: wrong read data on word 5
      push_exp(1'b0, 16'd20, 32'h0);
      bus(1'b0, 16'd20, 32'h0, pat(5) ^ 32'h1, 1);
      check("R9 pulse", 32'(mism_pulse), 1);
      check("R8 sticky", 32'(sticky_data), 1);
      check("R9 cnt", 32'(mism_cnt), 1);
      check("R9 cap_addr", 32'(cap_addr), 20);
      check("R9 cap_exp", cap_exp, pat(5));
      check("R9 cap_act", cap_act, pat(5) ^ 32'h1);
      check("R5 clean", 32'(sticky_dir), 0);
      check("R6 clean", 32'(sticky_addr), 0);
      @(negedge pclk);
      check("R9 pulse width", 32'(mism_pulse), 0);

      // R6: address mismatch; R7: expected write still updates shadow
      push_exp(1'b1, 16'd8, 32'h1234_5678);
      bus(1'b1, 16'd12, 32'h1234_5678, 32'h0, 0);
      check("R6 sticky", 32'(sticky_addr), 1);
      check("R6 cnt", 32'(mism_cnt), 2);
      check("R6 cap_addr", 32'(cap_addr), 12);
      push_exp(1'b0, 16'd8, 32'h0);
      bus(1'b0, 16'd8, 32'h0, 32'h1234_5678, 0);
      check("R7 updated word", 32'(mism_cnt), 2);

      // R5: expected read, observed write
      push_exp(1'b0, 16'd0, 32'h0);
      bus(1'b1, 16'd0, 32'hAAAA_5555, 32'h0, 0);
      check("R5 sticky", 32'(sticky_dir), 1);
      check("R5 cnt", 32'(mism_cnt), 3);
      check("R5 cap_act", cap_act, 32'hAAAA_5555);

      // R10: shadow cleared by reset
      do_reset();
      check("R10 sticky cleared", 32'({sticky_dir, sticky_addr, sticky_data}), 0);
      for (int i = 0; i < 16; i++) begin
         push_exp(1'b0, 16'(i * 4), 32'h0);
         bus(1'b0, 16'(i * 4), 32'h0, 32'h0, 0);
      end
      check("R10 shadow zero", 32'(mism_cnt), 0);

      // R2: order of consumption
      push_exp(1'b1, 16'd4, 32'h11);
      push_exp(1'b1, 16'd8, 32'h22);
      bus(1'b1, 16'd4, 32'h11, 32'h0, 0);
      bus(1'b1, 16'd8, 32'h22, 32'h0, 0);
      check("R2 in order", 32'(mism_cnt), 0);
      push_exp(1'b1, 16'd4, 32'h11);
      push_exp(1'b1, 16'd8, 32'h22);
      bus(1'b1, 16'd8, 32'h22, 32'h0, 0);
      bus(1'b1, 16'd4, 32'h11, 32'h0, 0);
      check("R2 swapped", 32'(mism_cnt), 2);

      // R3/R4: fill to depth, overflow, drain, one extra transfer
      do_reset();
      for (int i = 0; i < 8; i++) push_exp(1'b1, 16'(i * 4), pat(i + 20));
      check("R3 full no ovf", 32'(sticky_ovf), 0);
      push_exp(1'b1, 16'd60, 32'h0);
      check("R3 ovf", 32'(sticky_ovf), 1);
      for (int i = 0; i < 8; i++) bus(1'b1, 16'(i * 4), pat(i + 20), 32'h0, i % 2);
      check("R3 drain clean", 32'(mism_cnt), 0);
      check("R4 not yet", 32'(sticky_unexp), 0);
      bus(1'b1, 16'd60, 32'h0, 32'h0, 0);
      check("R4 unexp", 32'(sticky_unexp), 1);
      check("R4 pulse", 32'(mism_pulse), 0);
      check("R4 cnt", 32'(mism_cnt), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule